// File: doc/BRIEF.md
# NEC infrared frame transmitter

The block sends one NEC-style remote-control frame on a single modulated output that drives an infrared emitter stage. A one-clock `start` pulse latches an 8-bit address, an 8-bit command and an end-mark suppress flag. The block then emits a long leader burst and a leader gap. It follows with 32 data bits, each a carrier burst plus a short or long silent gap, and then a closing burst. The output stays silent until the fixed frame period has run out. `busy` covers the whole frame and `done` marks its end.

Every duration is counted in whole carrier periods derived from the system clock through one divider constant. Bursts therefore always begin on a fresh carrier period and end on a period boundary, so no partial carrier pulse is ever emitted. The carrier is high for the first quarter of each period. With the suppress flag set, the closing burst is left out while the frame period is kept, which makes a receiver reject the frame.

Top module: `nec_ir_tx`

## Requirements
- R1: While reset is held and after it, with no start accepted, `ir_out`, `busy` and `done` are all 0.
- R2: During a burst the output repeats a carrier period of CLK_PER_CYC clocks: high for the first CLK_PER_CYC/4 clocks, low for the rest. The first burst begins with a high phase in the first clock after the start is accepted.
- R3: The leader is LEAD_ON (339) carrier periods of burst followed by LEAD_OFF (170) periods of silence.
- R4: Every data bit is BIT_MARK (21) periods of burst, then GAP_ZERO (21) silent periods for a 0 or GAP_ONE (63) silent periods for a 1.
- R5: The 32 bits go out as four bytes in the order address, inverted address, command, inverted command, each byte least significant bit first.
- R6: With `skip_end` = 0, one closing burst of BIT_MARK periods follows the last bit, and the output then stays low until the frame ends.
- R7: With `skip_end` = 1 at start, no closing burst is sent, the output stays low from the end of the last bit's gap, and the frame length is unchanged.
- R8: `busy` is 1 from the clock after the accepted start for exactly FRAME_CYC*CLK_PER_CYC clocks. In the clock where it falls, `done` is 1 for that single clock.
- R9: A `start` pulse while `busy` is 1 is ignored: the running frame keeps its latched address, command and suppress flag and its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-clock request to send a frame, accepted only while idle |
| addr | input | 8 | Address byte, sampled on an accepted start |
| cmd | input | 8 | Command byte, sampled on an accepted start |
| skip_end | input | 1 | Leave out the closing burst, sampled on an accepted start |
| ir_out | output | 1 | Modulated emitter drive |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at the end of the frame period |

## Verification
Counting k as the number of clock edges after the edge that accepts `start`, `ir_out` at step k follows the burst map entry for period k/CLK_PER_CYC, gated by k mod CLK_PER_CYC being under the high count. `busy` is 1 for k below FRAME_CYC*CLK_PER_CYC, and `done` is 1 at exactly that k. The bench builds the burst map for each frame from the requirements, samples every output at the falling edge after each step k, and compares for every k of the frame and a stretch of idle cycles after it. A carrier of four clocks keeps a full frame to about 16,000 clocks while the period counts stay at their default values.

// File: rtl/nec_tx_pkg.sv
package nec_tx_pkg;

  typedef enum logic [2:0] {
    SEG_LEAD_ON,
    SEG_LEAD_OFF,
    SEG_MARK,
    SEG_SPACE,
    SEG_END,
    SEG_TAIL
  } seg_e;

  // Bit 0 of the result is the first bit on air.
  function automatic logic [31:0] frame_word(input logic [7:0] a, input logic [7:0] c);
    return {~c, c, ~a, a};
  endfunction

  function automatic int unsigned gap_periods(input logic b, input int unsigned short_gap,
                                              input int unsigned long_gap);
    return b ? long_gap : short_gap;
  endfunction

  function automatic logic seg_is_mark(input seg_e s);
    return (s == SEG_LEAD_ON) || (s == SEG_MARK) || (s == SEG_END);
  endfunction

endpackage

// File: rtl/nec_carrier_gen.sv
module nec_carrier_gen #(
  parameter int unsigned CLK_PER_CYC = 2632,
  parameter int unsigned HIGH_CLKS   = 658
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic cyc_first,
  output logic cyc_last,
  output logic car_hi
);
  localparam int unsigned W = (CLK_PER_CYC > 2) ? $clog2(CLK_PER_CYC) : 1;
  localparam logic [W-1:0] LAST = W'(CLK_PER_CYC - 1);
  localparam logic [W-1:0] HI   = W'(HIGH_CLKS);

  logic [W-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n)          pos <= '0;
    else if (!run)       pos <= '0;
    else if (pos == LAST) pos <= '0;
    else                 pos <= pos + W'(1);
  end

  assign cyc_first = run && (pos == '0);
  assign cyc_last  = run && (pos == LAST);
  assign car_hi    = run && (pos < HI);

  // R2: a period closes and the next one opens at phase zero
  assert_period_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc_last) |=> (pos == '0));

endmodule

// File: rtl/nec_frame_seq.sv
module nec_frame_seq
  import nec_tx_pkg::*;
#(
  parameter int unsigned LEAD_ON   = 339,
  parameter int unsigned LEAD_OFF  = 170,
  parameter int unsigned BIT_MARK  = 21,
  parameter int unsigned GAP_ZERO  = 21,
  parameter int unsigned GAP_ONE   = 63,
  parameter int unsigned FRAME_CYC = 4077
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] addr,
  input  logic [7:0] cmd,
  input  logic       skip_end,
  input  logic       cyc_last,
  output logic       busy,
  output logic       done,
  output logic       mark
);
  localparam int unsigned SW = $clog2(LEAD_ON + LEAD_OFF + BIT_MARK + GAP_ZERO + GAP_ONE + 1);
  localparam int unsigned FW = $clog2(FRAME_CYC + 1);

  seg_e          seg, seg_nx;
  logic [SW-1:0] seg_cnt, seg_len;
  logic [FW-1:0] frame_cnt;
  logic [31:0]   word;
  logic [4:0]    bit_idx;
  logic          skip_r;
  logic          seg_done, frame_end, accept;

  always_comb begin
    case (seg)
      SEG_LEAD_ON:  seg_len = SW'(LEAD_ON);
      SEG_LEAD_OFF: seg_len = SW'(LEAD_OFF);
      SEG_MARK:     seg_len = SW'(BIT_MARK);
      SEG_SPACE:    seg_len = SW'(gap_periods(word[0], GAP_ZERO, GAP_ONE));
      SEG_END:      seg_len = SW'(BIT_MARK);
      default:      seg_len = SW'(1);
    endcase
  end

  always_comb begin
    case (seg)
      SEG_LEAD_ON:  seg_nx = SEG_LEAD_OFF;
      SEG_LEAD_OFF: seg_nx = SEG_MARK;
      SEG_MARK:     seg_nx = SEG_SPACE;
      SEG_SPACE:    seg_nx = (bit_idx != 5'd31) ? SEG_MARK : (skip_r ? SEG_TAIL : SEG_END);
      default:      seg_nx = SEG_TAIL;
    endcase
  end

  assign accept    = start && !busy;
  assign seg_done  = cyc_last && (seg != SEG_TAIL) && (seg_cnt == seg_len - SW'(1));
  assign frame_end = cyc_last && (frame_cnt == FW'(FRAME_CYC - 1));
  assign mark      = busy && seg_is_mark(seg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      seg       <= SEG_TAIL;
      seg_cnt   <= '0;
      frame_cnt <= '0;
      word      <= '0;
      bit_idx   <= '0;
      skip_r    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        seg       <= SEG_LEAD_ON;
        seg_cnt   <= '0;
        frame_cnt <= '0;
        word      <= frame_word(addr, cmd);
        bit_idx   <= '0;
        skip_r    <= skip_end;
      end else if (busy && cyc_last) begin
        frame_cnt <= frame_cnt + FW'(1);
        if (frame_end) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        if (seg_done) begin
          seg     <= seg_nx;
          seg_cnt <= '0;
          if (seg == SEG_SPACE) begin
            word    <= word >> 1;
            bit_idx <= bit_idx + 5'd1;
          end
        end else if (seg != SEG_TAIL) begin
          seg_cnt <= seg_cnt + SW'(1);
        end
      end
    end
  end

  // R6: every burst and gap has finished before the frame period closes
  assert_frame_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (seg == SEG_TAIL));
  // R8: done lasts a single clock
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: done appears only as busy falls
  assert_done_with_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R9: the latched suppress flag holds for the whole frame
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(skip_r));

endmodule

// File: rtl/nec_ir_tx.sv
module nec_ir_tx #(
  parameter int unsigned CLK_PER_CYC = 2632,
  parameter int unsigned LEAD_ON     = 339,
  parameter int unsigned LEAD_OFF    = 170,
  parameter int unsigned BIT_MARK    = 21,
  parameter int unsigned GAP_ZERO    = 21,
  parameter int unsigned GAP_ONE     = 63,
  parameter int unsigned FRAME_CYC   = 4077
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] addr,
  input  logic [7:0] cmd,
  input  logic       skip_end,
  output logic       ir_out,
  output logic       busy,
  output logic       done
);
  localparam int unsigned HIGH_CLKS = CLK_PER_CYC / 4;

  logic cyc_first, cyc_last, car_hi, mark;

  nec_carrier_gen #(
    .CLK_PER_CYC(CLK_PER_CYC),
    .HIGH_CLKS  (HIGH_CLKS)
  ) u_carrier (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .cyc_first(cyc_first),
    .cyc_last (cyc_last),
    .car_hi   (car_hi)
  );

  nec_frame_seq #(
    .LEAD_ON  (LEAD_ON),
    .LEAD_OFF (LEAD_OFF),
    .BIT_MARK (BIT_MARK),
    .GAP_ZERO (GAP_ZERO),
    .GAP_ONE  (GAP_ONE),
    .FRAME_CYC(FRAME_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .addr     (addr),
    .cmd      (cmd),
    .skip_end (skip_end),
    .cyc_last (cyc_last),
    .busy     (busy),
    .done     (done),
    .mark     (mark)
  );

  assign ir_out = mark && car_hi;

  // R2: a burst never starts part way into a carrier period
  assert_mark_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ir_out) |-> cyc_first);
  // R1: no emission outside a frame
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ir_out);

endmodule

// File: tb/test_nec_ir_tx.sv
`timescale 1ns/1ps
module test_nec_ir_tx;
  localparam int D     = 4;
  localparam int H     = D / 4;
  localparam int FRAME = 4077;
  localparam int TOT   = FRAME * D;

  // {addr, cmd, skip_end}
  localparam logic [16:0] VEC [4] = '{
    {8'h00, 8'hFF, 1'b0},
    {8'hA5, 8'h3C, 1'b0},
    {8'hFF, 8'h00, 1'b1},
    {8'h5A, 8'hC3, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, skip_end = 1'b0;
  logic [7:0] addr = '0, cmd = '0;
  logic ir_out, busy, done;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic exp_map [0:FRAME-1];
  int bits_end;

  always #5 clk = ~clk;

  nec_ir_tx #(.CLK_PER_CYC(D)) i_nec_ir_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .cmd(cmd),
    .skip_end(skip_end), .ir_out(ir_out), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic put(inout int p, input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      exp_map[p] = v;
      p++;
    end
  endtask

  task automatic build_map(input logic [7:0] a, input logic [7:0] c, input logic s);
    int p = 0;
    logic [7:0] by;
    for (int i = 0; i < FRAME; i++) exp_map[i] = 1'b0;
    put(p, 339, 1'b1);
    put(p, 170, 1'b0);
    for (int b = 0; b < 32; b++) begin
      case (b / 8)
        0: by = a;
        1: by = ~a;
        2: by = c;
        default: by = ~c;
      endcase
      put(p, 21, 1'b1);
      put(p, by[b % 8] ? 63 : 21, 1'b0);
    end
    bits_end = p;
    if (!s) put(p, 21, 1'b1);
  endtask

  task automatic run_frame(input logic [7:0] a, input logic [7:0] c, input logic s,
                           input bit inject, input bit first);
    int err [4];
    int ek [4], ea [4], ee [4];
    int p, reg_i;
    logic eir;
    string tail_tag;
    for (int r = 0; r < 4; r++) begin err[r] = 0; ek[r] = 0; ea[r] = 0; ee[r] = 0; end
    build_map(a, c, s);
    @(negedge clk);
    addr = a; cmd = c; skip_end = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= TOT + 20; k++) begin
      if (k < TOT) begin
        p = k / D;
        eir = exp_map[p] && ((k % D) < H);
        reg_i = (p < 509) ? 0 : ((p < bits_end) ? 1 : 2);
        if (ir_out !== eir && err[reg_i]++ == 0) begin ek[reg_i] = k; ea[reg_i] = int'(ir_out); ee[reg_i] = int'(eir); end
        if ((busy !== 1'b1 || done !== 1'b0) && err[3]++ == 0) begin ek[3] = k; ea[3] = int'(busy); ee[3] = 1; end
        if (first && k < D) check(ir_out === (k < H), "R2", "carrier phase in first period", int'(ir_out), int'(k < H));
      end else if (k == TOT) begin
        check(busy === 1'b0, "R8", "busy at frame end", int'(busy), 0);
        check(done === 1'b1, "R8", "done at frame end", int'(done), 1);
      end else begin
        if ((ir_out !== 1'b0 || done !== 1'b0 || busy !== 1'b0) && err[2]++ == 0) begin
          ek[2] = k; ea[2] = int'({ir_out, done, busy}); ee[2] = 0;
        end
      end
      if (inject && k == 500) begin start = 1'b1; addr = ~a; cmd = ~c; skip_end = ~s; end
      if (inject && k == 501) start = 1'b0;
      @(negedge clk);
    end
    tail_tag = s ? "R7" : "R6";
    check(err[0] == 0, "R3", $sformatf("leader waveform, first miss at clk %0d", ek[0]), ea[0], ee[0]);
    check(err[1] == 0, "R4 R5", $sformatf("data bit waveform, first miss at clk %0d", ek[1]), ea[1], ee[1]);
    check(err[2] == 0, tail_tag, $sformatf("closing part, first miss at clk %0d", ek[2]), ea[2], ee[2]);
    check(err[3] == 0, "R8", $sformatf("busy during frame, first miss at clk %0d", ek[3]), ea[3], ee[3]);
    if (inject)
      check(err[0] + err[1] + err[2] + err[3] == 0, "R9", "frame disturbed by start while busy",
            err[0] + err[1] + err[2] + err[3], 0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(ir_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "outputs in reset",
          int'({ir_out, busy, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ir_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "outputs idle after reset",
          int'({ir_out, busy, done}), 0);
    for (int v = 0; v < 4; v++)
      run_frame(VEC[v][16:9], VEC[v][8:1], VEC[v][0], 1'b0, v == 0);
    // R9: second start in mid-frame with different inputs
    run_frame(8'h36, 8'h81, 1'b0, 1'b1, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule